// File: doc/BRIEF.md
# SD Host Interrupt Status and Error Classifier

This block keeps the interrupt bookkeeping of an SD card host. Nine single-cycle event pulses come in from the card-side logic. Each pulse sets a sticky status bit, and software clears a status bit by writing a one to it. A separate enable register selects which status bits drive the interrupt line. The interrupt line is high whenever at least one bit is both enabled and pending.

A small sequencer follows each command from start to end. The command is started by `cmd_go_i`, which also captures whether the command moves data, and it ends with `xfer_done_i`. At the end the sequencer classifies the pending status into a two-bit command error code and a two-bit data error code, each resolved by a fixed priority. It also requests either a full soft reset or a FIFO flush, and issues a one-cycle report. In the cycle after the report it clears every enable bit and acknowledges every pending status bit.

The sequencer has three states:
- `ST_IDLE`: waits for `cmd_go_i`. This transition is named *launch*.
- `ST_ACTIVE`: waits for `xfer_done_i`. This transition is named *finish*, and it latches the verdict.
- `ST_REPORT`: lasts one cycle, then returns to `ST_IDLE`. This transition is named *retire*, and it clears the enables and the status.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_i[k]` sets status bit k at the next clock edge, and the bit stays set until it is cleared. The bit positions are: 0 response OK, 1 response CRC error, 2 response timeout, 3 data CRC error, 4 data timeout, 5 RX FIFO full, 6 TX FIFO empty, 7 data transfer OK, 8 DMA done.
- R2: A write with `reg_sel_i`=1 clears every status bit whose `reg_wdata_i` bit is one. Status bits written with zero keep their value.
- R3: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R4: `irq_o` is high exactly when the bitwise AND of the enable register and the status register is non-zero.
- R5: A write with `reg_sel_i`=0 loads the enable register. `reg_rdata_i` returns the enable register when `reg_sel_i`=0 and the status register when `reg_sel_i`=1.
- R6: The command error code is resolved in this priority order, using the codes 0 none, 1 I/O, 2 CRC, 3 timeout:
  - status bit 5 or bit 6 set gives 1 (I/O);
  - otherwise bit 1 set gives 2 (CRC);
  - otherwise bit 2 set gives 3 (timeout);
  - otherwise 0.
- R7: The data error code is 0 for a command launched without data. For a data command it is 2 if bit 3 is set, otherwise 3 if bit 4 is set, otherwise 0. The data error code is never 1.
- R8: `rpt_vld_o` is high for exactly one cycle: the cycle after the edge at which `xfer_done_i` is seen in `ST_ACTIVE`. The codes and reset requests are valid in that cycle, and both registers read zero one cycle later (status bits for new events excepted).
- R9: During the report, `full_rst_o` is high when the command error code is I/O or timeout. `fifo_rst_o` is high for a data command when `full_rst_o` is low. The two are never high together, and neither is high outside the report.
- R10: `cmd_go_i` is ignored outside `ST_IDLE`, including its data flag. `xfer_done_i` is ignored outside `ST_ACTIVE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 9 | Event pulses, one per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the enable register, 1 selects the status register |
| reg_wdata_i | input | 9 | Write data |
| reg_rdata_o | output | 9 | Read data of the selected register |
| cmd_go_i | input | 1 | Command launch pulse |
| cmd_data_i | input | 1 | Launched command moves data |
| xfer_done_i | input | 1 | Command/transfer end pulse |
| irq_o | output | 1 | Interrupt request |
| rpt_vld_o | output | 1 | One-cycle report strobe |
| cmd_err_o | output | 2 | Command error code |
| dat_err_o | output | 2 | Data error code |
| full_rst_o | output | 1 | Full soft reset request |
| fifo_rst_o | output | 1 | FIFO flush request |

## Verification
Status, enable and `irq_o` all change one edge after the event pulse or register write that causes them. The bench drives stimulus on falling edges and samples on the next falling edge. The report and its codes appear one edge after `xfer_done_i`, and the cleared registers appear one edge after that. The driver task therefore queues the expected verdict, and a monitor pops and compares it on the falling edge where `rpt_vld_o` is high. Register reads are combinational, so they are checked a short delay after `reg_sel_i` changes.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
    localparam int EV_CNT      = 9;
    localparam int EV_RESP_OK  = 0;
    localparam int EV_RESP_CRC = 1;
    localparam int EV_RESP_TMO = 2;
    localparam int EV_DAT_CRC  = 3;
    localparam int EV_DAT_TMO  = 4;
    localparam int EV_RX_FULL  = 5;
    localparam int EV_TX_EMPTY = 6;
    localparam int EV_XFER_OK  = 7;
    localparam int EV_DMA_DONE = 8;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_IO   = 2'd1,
        ERR_CRC  = 2'd2,
        ERR_TMO  = 2'd3
    } err_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_REPORT = 2'd2
    } seq_st_t;

    typedef struct packed {
        err_t cmd;
        err_t dat;
        logic full_rst;
        logic fifo_rst;
    } verdict_t;
endpackage

// File: rtl/sdh_evt_latch.sv
module sdh_evt_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] w1c_i,
    input  logic         clr_all_i,
    output logic [W-1:0] sta_o
);
    logic [W-1:0] sta_q;
    logic [W-1:0] kept;

    // a new event always wins over any clear in the same cycle
    always_comb kept = clr_all_i ? '0 : (sta_q & ~w1c_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sta_q <= '0;
        else        sta_q <= kept | set_i;
    end

    assign sta_o = sta_q;
endmodule

// File: rtl/sdh_err_classify.sv
module sdh_err_classify
    import sdh_irq_pkg::*;
#(
    parameter int W = EV_CNT
) (
    input  logic [W-1:0] sta_i,
    input  logic         has_data_i,
    output verdict_t     verdict_o
);
    always_comb begin
        verdict_o = '{cmd: ERR_NONE, dat: ERR_NONE, full_rst: 1'b0, fifo_rst: 1'b0};
        if (sta_i[EV_RX_FULL] || sta_i[EV_TX_EMPTY]) verdict_o.cmd = ERR_IO;
        else if (sta_i[EV_RESP_CRC])                 verdict_o.cmd = ERR_CRC;
        else if (sta_i[EV_RESP_TMO])                 verdict_o.cmd = ERR_TMO;
        if (has_data_i) begin
            if (sta_i[EV_DAT_CRC])      verdict_o.dat = ERR_CRC;
            else if (sta_i[EV_DAT_TMO]) verdict_o.dat = ERR_TMO;
        end
        verdict_o.full_rst = (verdict_o.cmd == ERR_IO) || (verdict_o.cmd == ERR_TMO);
        verdict_o.fifo_rst = has_data_i && !verdict_o.full_rst;
    end
endmodule

// File: rtl/sdh_irq_seq.sv
module sdh_irq_seq
    import sdh_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_go_i,
    input  logic     cmd_data_i,
    input  logic     xfer_done_i,
    input  verdict_t verdict_i,
    output logic     has_data_o,
    output logic     rpt_vld_o,
    output logic     clr_all_o,
    output verdict_t verdict_o
);
    seq_st_t  state_q, state_d;
    logic     data_q;
    verdict_t held_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_go_i)    state_d = ST_ACTIVE;   // launch
            ST_ACTIVE: if (xfer_done_i) state_d = ST_REPORT;   // finish
            ST_REPORT:                  state_d = ST_IDLE;     // retire
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= 1'b0;
            held_q <= '{cmd: ERR_NONE, dat: ERR_NONE, full_rst: 1'b0, fifo_rst: 1'b0};
        end else begin
            if (state_q == ST_IDLE && cmd_go_i)       data_q <= cmd_data_i;
            if (state_q == ST_ACTIVE && xfer_done_i)  held_q <= verdict_i;
        end
    end

    always_comb begin
        rpt_vld_o  = 1'b0;
        clr_all_o  = 1'b0;
        has_data_o = data_q;
        verdict_o  = held_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACTIVE: ;
            ST_REPORT: begin
                rpt_vld_o = 1'b1;
                clr_all_o = 1'b1;
            end
            default:   ;
        endcase
        if (!rpt_vld_o) begin
            verdict_o.full_rst = 1'b0;
            verdict_o.fifo_rst = 1'b0;
        end
    end
endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
    import sdh_irq_pkg::*;
#(
    parameter int N_EVT = EV_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_i,
    input  logic [N_EVT-1:0] reg_wdata_i,
    output logic [N_EVT-1:0] reg_rdata_o,
    input  logic             cmd_go_i,
    input  logic             cmd_data_i,
    input  logic             xfer_done_i,
    output logic             irq_o,
    output logic             rpt_vld_o,
    output logic [1:0]       cmd_err_o,
    output logic [1:0]       dat_err_o,
    output logic             full_rst_o,
    output logic             fifo_rst_o
);
    logic [N_EVT-1:0] en_q;
    logic [N_EVT-1:0] sta;
    logic [N_EVT-1:0] w1c;
    logic             clr_all;
    logic             has_data;
    verdict_t         verdict_now;
    verdict_t         verdict_out;

    assign w1c = (reg_wr_i && reg_sel_i) ? reg_wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      en_q <= '0;
        else if (clr_all)                en_q <= '0;
        else if (reg_wr_i && !reg_sel_i) en_q <= reg_wdata_i;
    end

    sdh_evt_latch #(.W(N_EVT)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_i),
        .w1c_i    (w1c),
        .clr_all_i(clr_all),
        .sta_o    (sta)
    );

    sdh_err_classify #(.W(N_EVT)) u_class (
        .sta_i     (sta),
        .has_data_i(has_data),
        .verdict_o (verdict_now)
    );

    sdh_irq_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go_i   (cmd_go_i),
        .cmd_data_i (cmd_data_i),
        .xfer_done_i(xfer_done_i),
        .verdict_i  (verdict_now),
        .has_data_o (has_data),
        .rpt_vld_o  (rpt_vld_o),
        .clr_all_o  (clr_all),
        .verdict_o  (verdict_out)
    );

    assign irq_o       = |(en_q & sta);
    assign reg_rdata_o = reg_sel_i ? sta : en_q;
    assign cmd_err_o   = verdict_out.cmd;
    assign dat_err_o   = verdict_out.dat;
    assign full_rst_o  = verdict_out.full_rst;
    assign fifo_rst_o  = verdict_out.fifo_rst;
endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk #(
    parameter int W = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt,
    input logic         reg_wr,
    input logic         reg_sel,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] en,
    input logic [W-1:0] sta,
    input logic         rpt_vld,
    input logic [1:0]   dat_err,
    input logic         full_rst,
    input logic         fifo_rst
);
    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((sta & $past(evt)) == $past(evt)));

    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> ((sta & $past(reg_wdata & ~evt)) == '0));

    p_en_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !rpt_vld) |=> (en == $past(reg_wdata)));

    p_dat_never_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |-> (dat_err != 2'd1));

    p_report_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |=> !rpt_vld);

    p_report_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_vld |=> (en == '0 && (sta & ~$past(evt)) == '0));

    p_reset_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_rst && fifo_rst));

    p_req_in_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rst || fifo_rst) |-> rpt_vld);
endmodule

bind sdh_irq_ctrl sdh_irq_chk #(.W(N_EVT)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .reg_wr   (reg_wr_i),
    .reg_sel  (reg_sel_i),
    .reg_wdata(reg_wdata_i),
    .en       (en_q),
    .sta      (sta),
    .rpt_vld  (rpt_vld_o),
    .dat_err  (dat_err_o),
    .full_rst (full_rst_o),
    .fifo_rst (fifo_rst_o)
);

// File: tb/test_sdh_irq_ctrl.sv
`timescale 1ns/1ps
module test_sdh_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] evt_i = '0;
    logic       reg_wr_i = 1'b0;
    logic       reg_sel_i = 1'b0;
    logic [8:0] reg_wdata_i = '0;
    logic [8:0] reg_rdata_o;
    logic       cmd_go_i = 1'b0;
    logic       cmd_data_i = 1'b0;
    logic       xfer_done_i = 1'b0;
    logic       irq_o, rpt_vld_o, full_rst_o, fifo_rst_o;
    logic [1:0] cmd_err_o, dat_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [5:0] exp_q[$];

    always #10 clk = ~clk;

    sdh_irq_ctrl i_sdh_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
        .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .cmd_go_i(cmd_go_i), .cmd_data_i(cmd_data_i), .xfer_done_i(xfer_done_i),
        .irq_o(irq_o), .rpt_vld_o(rpt_vld_o), .cmd_err_o(cmd_err_o),
        .dat_err_o(dat_err_o), .full_rst_o(full_rst_o), .fifo_rst_o(fifo_rst_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected verdict {cmd[1:0], dat[1:0], full, fifo} from R6, R7, R9
    function automatic logic [5:0] predict(bit dat, logic [8:0] s);
        logic [1:0] c, d;
        logic f;
        c = (s[5] || s[6]) ? 2'd1 : s[1] ? 2'd2 : s[2] ? 2'd3 : 2'd0;
        d = !dat ? 2'd0 : s[3] ? 2'd2 : s[4] ? 2'd3 : 2'd0;
        f = (c == 2'd1) || (c == 2'd3);
        return {c, d, f, dat & ~f};
    endfunction

    // monitor: compares each report against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rpt_vld_o) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8: actual unexpected report expected none");
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                if ({cmd_err_o, dat_err_o, full_rst_o, fifo_rst_o} !== e) begin
                    n_bad++;
                    $display("FAIL R6/R7/R9 verdict: actual %0h expected %0h",
                             {cmd_err_o, dat_err_o, full_rst_o, fifo_rst_o}, e);
                end
            end
        end
    end

    task automatic wr(bit sel, logic [8:0] d);
        reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(string tag, bit sel, logic [8:0] exp);
        reg_sel_i = sel;
        #1;
        check(tag, reg_rdata_o, exp);
    endtask

    task automatic pulse(logic [8:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic run_cmd(bit dat, logic [8:0] ev);
        exp_q.push_back(predict(dat, ev));
        cmd_go_i = 1'b1; cmd_data_i = dat;
        @(negedge clk);
        cmd_go_i = 1'b0; cmd_data_i = 1'b0;
        pulse(ev);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;   // report visible here
        @(negedge clk);       // registers cleared here
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R5 reset enable", 1'b0, 9'h000);
        rd("R1 reset status", 1'b1, 9'h000);
        check("R4 reset irq", irq_o, 0);
        check("R8 reset report", rpt_vld_o, 0);

        // R5 enable load and readback
        wr(1'b0, 9'h008);
        rd("R5 enable readback", 1'b0, 9'h008);

        // R1 sticky set, R4 irq only on overlap
        pulse(9'h020);
        rd("R1 rx full latched", 1'b1, 9'h020);
        check("R4 irq masked", irq_o, 0);
        pulse(9'h008);
        rd("R1 sticky bits", 1'b1, 9'h028);
        check("R4 irq on overlap", irq_o, 1);
        wr(1'b0, 9'h000);
        check("R4 irq after disable", irq_o, 0);

        // R2 write-one-to-clear, zeros keep bits
        wr(1'b1, 9'h008);
        rd("R2 w1c partial", 1'b1, 9'h020);
        wr(1'b1, 9'h000);
        rd("R2 zero write keeps", 1'b1, 9'h020);

        // R3 event wins over same-cycle clear
        reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 9'h020; evt_i = 9'h020;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0; evt_i = '0;
        rd("R3 set wins", 1'b1, 9'h020);
        wr(1'b1, 9'h1FF);
        rd("R2 clear all", 1'b1, 9'h000);

        // R6 R7 R9 verdicts over several event mixes
        wr(1'b0, 9'h1FF);
        run_cmd(1'b0, 9'h001);
        rd("R8 enables cleared", 1'b0, 9'h000);
        rd("R8 status cleared", 1'b1, 9'h000);
        run_cmd(1'b1, 9'h180);
        run_cmd(1'b1, 9'h022);
        run_cmd(1'b0, 9'h006);
        run_cmd(1'b0, 9'h004);
        run_cmd(1'b1, 9'h018);
        run_cmd(1'b1, 9'h010);
        run_cmd(1'b0, 9'h008);
        run_cmd(1'b1, 9'h040);

        // R10 done while idle ignored
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        check("R10 done in idle", rpt_vld_o, 0);
        @(negedge clk);
        check("R10 done in idle later", rpt_vld_o, 0);

        // R10 second launch while active ignored (data flag not taken)
        exp_q.push_back(predict(1'b0, 9'h00A));
        cmd_go_i = 1'b1; cmd_data_i = 1'b0;
        @(negedge clk);
        cmd_data_i = 1'b1;
        evt_i = 9'h00A;
        @(negedge clk);
        cmd_go_i = 1'b0; cmd_data_i = 1'b0; evt_i = '0;
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        @(negedge clk);
        check("R8 report once", rpt_vld_o, 0);
        check("R8 all reports seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule